// File: doc/BRIEF.md
# Block-Transfer Serial Configuration Slave

This block is a two-wire serial slave that owns six 8-bit configuration bytes and presents them to the rest of the chip as one parallel vector. A host changes them only with whole-block transfers, and there is no register index inside a transfer. A write always begins at byte 0 and moves upward one byte at a time. A read always returns a length byte and then the stored bytes in ascending order.

The clock and data lines are sampled on the system clock through two-flop synchronizers. Start and stop conditions are found from the sampled lines. The slave pulls the data line low through an open-drain enable and never drives it high. On a write, the first two bytes after the device address are acknowledged and thrown away. Each byte after that lands in the next register. A stop after any complete byte ends the write. Registers already written keep their new values and the rest stay as they were. A repeated start or a stop at any bit position returns the engine to address reception or to idle.

Top module: `blkcfg_slave`

## Requirements
- R1: After reset the parallel output holds the parameter defaults, with register k at bits [8k+7:8k], and the data-line enable is off.
- R2: The slave acknowledges only the address byte 0xD2 (write) and 0xD3 (read). For any other address byte it leaves the data line released for the whole transfer.
- R3: On a write, the two bytes after the address are acknowledged and have no effect on any register. Byte number k (k starting at 0) after those two is stored in register k.
- R4: A stop after any complete data byte keeps every register already written in that transfer and leaves all later registers at their previous values.
- R5: Write bytes beyond register 5 are acknowledged and ignored. The write pointer saturates and never wraps to register 0.
- R6: A read sends, MSB first, a length byte equal to 6 and then registers 0 to 5 in ascending order. Each byte is followed by a clock on which the host acknowledges.
- R7: When the host does not acknowledge (data high on the ninth clock), the slave releases the data line and keeps it released until the next start. The next transfer then works normally.
- R8: A start condition (data falls while the clock is high) at any bit position restarts address reception. A stop condition (data rises while the clock is high) returns the slave to idle.
- R9: The slave changes its data-line enable only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls the data line low when 1 (open drain) |
| cfg_bytes | output | 48 | Configuration registers, register k at bits [8k+7:8k] |

## Verification
Writes of every length from zero to six data bytes are each followed by a full read. A wrong pointer start, a skipped dummy byte or a write past the stop point then shows up as a byte in the wrong place. An overlong write shows whether the pointer saturates or wraps. A set of address bytes one bit away from the two valid ones shows whether the address compare checks every bit, including the direction bit. Reads that end with a host NACK after each possible byte, starts issued inside a byte, and a repeated start between a write and a read show whether the engine restarts cleanly from any point.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ADDR,
    XS_ADDR_ACK,
    XS_WDATA,
    XS_WACK,
    XS_RDATA,
    XS_RACK,
    XS_PARK
  } xfer_state_e;

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '1;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise = scl_s & ~scl_prev_q;
    scl_fall = ~scl_s & scl_prev_q;
    start_p  = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_p   = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end

  AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p && stop_p)); // R8
  AST_COND_STEADY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || stop_p) |-> !(scl_rise || scl_fall)); // R8

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int              NREG     = 6,
  parameter logic [NREG*8-1:0] DEFAULTS = '0,
  localparam int             SW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_sel,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_o
);

  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_reg
      logic [7:0] byte_q, byte_d;
      logic       hit;
      assign hit = wr_en && (wr_sel == SW'(k));
      always_comb begin
        byte_d = byte_q;
        if (hit) byte_d = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   byte_q <= DEFAULTS[8*k +: 8];
        else if (hit) byte_q <= byte_d;
      end
      assign regs_o[8*k +: 8] = byte_q;
    end
  endgenerate

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R4
  AST_BANK_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_sel) < NREG)); // R5

endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
  import blkcfg_pkg::*;
#(
  parameter int          NREG     = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  localparam int         SW       = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int         PW       = $clog2(NREG + 1),
  localparam int         WW       = $clog2(NREG + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [NREG*8-1:0] regs_i,
  output logic              wr_en_o,
  output logic [SW-1:0]     wr_sel_o,
  output logic [7:0]        wr_data_o,
  output logic              sda_oe_o
);

  localparam logic [7:0]    WR_ADDR  = {DEV_ADDR, 1'b0};
  localparam logic [7:0]    RD_ADDR  = {DEV_ADDR, 1'b1};
  localparam logic [7:0]    LEN_BYTE = 8'(NREG);
  localparam int            TXD      = 2 ** PW;
  localparam logic [WW-1:0] W_FIRST  = WW'(2);
  localparam logic [WW-1:0] W_LIMIT  = WW'(NREG + 2);
  localparam logic [PW-1:0] R_LIMIT  = PW'(NREG);

  xfer_state_e   state_q, state_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d;
  logic          oe_q, oe_d;
  logic          rnw_q, rnw_d;
  logic          hack_q, hack_d;
  logic [WW-1:0] widx_q, widx_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic [7:0]    tx_arr [TXD];
  logic [7:0]    tx_next;

  genvar j;
  generate
    for (j = 0; j < TXD; j++) begin : g_tx
      if (j < NREG) begin : g_reg
        assign tx_arr[j] = regs_i[8*j +: 8];
      end else begin : g_pad
        assign tx_arr[j] = 8'hFF;
      end
    end
  endgenerate

  assign tx_next   = tx_arr[ptr_q];
  assign wr_data_o = sh_q;
  assign sda_oe_o  = oe_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    rnw_d    = rnw_q;
    hack_d   = hack_q;
    widx_d   = widx_q;
    ptr_d    = ptr_q;
    wr_en_o  = 1'b0;
    wr_sel_o = '0;
    if (start_p) begin
      state_d = XS_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_p) begin
      state_d = XS_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        XS_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = '0;
            if (sh_q == WR_ADDR || sh_q == RD_ADDR) begin
              oe_d    = 1'b1;
              rnw_d   = sh_q[0];
              state_d = XS_ADDR_ACK;
            end else begin
              state_d = XS_PARK;
            end
          end
        end
        XS_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rnw_q) begin
              state_d = XS_RDATA;
              sh_d    = LEN_BYTE;
              oe_d    = ~LEN_BYTE[7];
              ptr_d   = '0;
            end else begin
              state_d = XS_WDATA;
              oe_d    = 1'b0;
              widx_d  = '0;
            end
          end
        end
        XS_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d   = '0;
            oe_d    = 1'b1;
            state_d = XS_WACK;
            if (widx_q >= W_FIRST && widx_q < W_LIMIT) begin
              wr_en_o  = 1'b1;
              wr_sel_o = SW'(widx_q - W_FIRST);
            end
            if (widx_q < W_LIMIT) widx_d = widx_q + WW'(1);
          end
        end
        XS_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = XS_WDATA;
          end
        end
        XS_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              cnt_d   = '0;
              oe_d    = 1'b0;
              state_d = XS_RACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b1};
              oe_d = ~sh_q[6];
            end
          end
        end
        XS_RACK: begin
          if (scl_rise) begin
            hack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (hack_q) begin
              state_d = XS_RDATA;
              sh_d    = tx_next;
              oe_d    = ~tx_next[7];
              if (ptr_q < R_LIMIT) ptr_d = ptr_q + PW'(1);
            end else begin
              state_d = XS_PARK;
              oe_d    = 1'b0;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      rnw_q   <= 1'b0;
      hack_q  <= 1'b0;
      widx_q  <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      rnw_q   <= rnw_d;
      hack_q  <= hack_d;
      widx_q  <= widx_d;
      ptr_q   <= ptr_d;
    end
  end

  AST_PULL_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s); // R9
  AST_ACK_ONLY_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_q) && $past(state_q) == XS_ADDR) |->
      ($past(sh_q) == WR_ADDR || $past(sh_q) == RD_ADDR)); // R2
  AST_WPTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    widx_q <= W_LIMIT); // R5
  AST_RPTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= R_LIMIT); // R6
  AST_STORE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (state_q == XS_WDATA && !rnw_q)); // R3
  AST_PARK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_PARK || state_q == XS_IDLE) |-> !oe_q); // R7
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (state_q == XS_ADDR && cnt_q == 4'd0)); // R8

endmodule

// File: rtl/blkcfg_slave.sv
module blkcfg_slave #(
  parameter int                NREG     = 6,
  parameter logic [6:0]        DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] DEFAULTS = 48'h24_7E_81_0F_C3_5A,
  localparam int               SW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_bytes
);

  logic          rst_meta_q, rst_sync_q;
  logic [1:0]    line_s;
  logic          scl_rise, scl_fall, start_p, stop_p;
  logic          wr_en;
  logic [SW-1:0] wr_sel;
  logic [7:0]    wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bus_line_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   ({scl_in, sda_in}),
    .q_o   (line_s)
  );

  bus_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .scl_s    (line_s[1]),
    .sda_s    (line_s[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  blk_xfer_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .regs_i    (cfg_bytes),
    .wr_en_o   (wr_en),
    .wr_sel_o  (wr_sel),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe)
  );

  cfg_reg_bank #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_o  (cfg_bytes)
  );

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    (rst_n && !rst_sync_q) |=> (rst_sync_q || cfg_bytes == DEFAULTS)); // R1

endmodule

// File: tb/blkcfg_slave_test.sv
module blkcfg_slave_test;

  localparam int          NREG = 6;
  localparam int          Q    = 10;
  localparam logic [47:0] DEF  = 48'h24_7E_81_0F_C3_5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_pull = 1'b0;
  logic        sda_pull = 1'b0;
  logic        scl_line, sda_line;
  logic        sda_oe;
  logic [47:0] cfg_bytes;

  int total = 0;
  int bad   = 0;
  int r9_viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  assign scl_line = ~scl_pull;
  assign sda_line = ~(sda_pull | sda_oe);

  blkcfg_slave #(.NREG(NREG), .DEFAULTS(DEF)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_line),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .cfg_bytes (cfg_bytes)
  );

  // R9 monitor: enable may change only while the clock line is low
  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_line) r9_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [47:0] model_flat();
    logic [47:0] v;
    for (int k = 0; k < NREG; k++) v[8*k +: 8] = model[k];
    return v;
  endfunction

  task automatic bus_start();
    sda_pull = 1'b0; wq(Q);
    scl_pull = 1'b0; wq(Q);
    sda_pull = 1'b1; wq(Q);
    scl_pull = 1'b1; wq(Q);
  endtask

  task automatic bus_stop();
    sda_pull = 1'b1; wq(Q);
    scl_pull = 1'b0; wq(Q);
    sda_pull = 1'b0; wq(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_pull = ~b[i]; wq(Q);
      scl_pull = 1'b0;  wq(2*Q);
      scl_pull = 1'b1;  wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_pull = 1'b0; wq(Q);
    scl_pull = 1'b0; wq(Q);
    ack = (sda_line == 1'b0);
    wq(Q);
    scl_pull = 1'b1; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_pull = 1'b0; wq(Q);
      b[i] = sda_line;
      wq(Q);
      scl_pull = 1'b1;
    end
    sda_pull = give_ack; wq(Q);
    scl_pull = 1'b0;     wq(2*Q);
    scl_pull = 1'b1;     wq(Q);
    sda_pull = 1'b0;
  endtask

  // write n data bytes after the two dummy bytes; checks every ACK (R3, R5)
  task automatic do_write(input int n, input int seed);
    bit ack;
    bus_start();
    send_byte(8'hD2, ack);
    chk(ack, "R2 write address ack", 64'(ack), 64'd1);
    send_byte(8'(8'hA5 + seed), ack);
    chk(ack, "R3 dummy command ack", 64'(ack), 64'd1);
    send_byte(8'(8'h3C ^ seed), ack);
    chk(ack, "R3 dummy count ack", 64'(ack), 64'd1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'((k + 1) * 8'h27 + seed * 8'h13);
      send_byte(d, ack);
      chk(ack, (k < NREG) ? "R3 data ack" : "R5 overflow ack", 64'(ack), 64'd1);
      if (k < NREG) model[k] = d;
    end
    bus_stop();
  endtask

  // read count plus nbytes registers; last byte NACKed
  task automatic do_read(input int nbytes);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, ack);
    chk(ack, "R2 read address ack", 64'(ack), 64'd1);
    recv_byte(nbytes > 0, b);
    chk(b == 8'd6, "R6 length byte", 64'(b), 64'd6);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(k < nbytes - 1, b);
      chk(b == model[k], $sformatf("R6 read reg%0d", k), 64'(b), 64'(model[k]));
    end
    // R7: after NACK, one more clock must see the line released
    wq(Q); scl_pull = 1'b0; wq(Q);
    chk(sda_line == 1'b1, "R7 released after nack", 64'(sda_line), 64'd1);
    wq(Q); scl_pull = 1'b1; wq(Q);
    bus_stop();
  endtask

  task automatic finish_run();
    chk(r9_viol == 0, "R9 enable moved with clock high", 64'(r9_viol), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    for (int k = 0; k < NREG; k++) model[k] = DEF[8*k +: 8];
    wq(5);
    chk(cfg_bytes == DEF, "R1 reset defaults (in reset)", 64'(cfg_bytes), 64'(DEF));
    rst_n = 1'b1;
    wq(5);
    chk(cfg_bytes == DEF, "R1 defaults after release", 64'(cfg_bytes), 64'(DEF));
    chk(sda_oe == 1'b0, "R1 enable off", 64'(sda_oe), 64'd0);

    // R2: addresses one bit away from the valid ones
    for (int i = 0; i < 8; i++) begin
      for (int base = 0; base < 2; base++) begin
        logic [7:0] a;
        bit exp;
        int oe_seen;
        a = (base == 0 ? 8'hD2 : 8'hD3) ^ 8'(1 << i);
        exp = (a == 8'hD2 || a == 8'hD3);
        bus_start();
        send_byte(a, ack);
        chk(ack == exp, $sformatf("R2 address %h", a), 64'(ack), 64'(exp));
        if (!exp) begin
          oe_seen = 0;
          for (int t = 0; t < 2; t++) begin
            send_bits(8'h00, 8);
            sda_pull = 1'b0; wq(Q);
            scl_pull = 1'b0; wq(Q);
            if (sda_line == 1'b0) oe_seen++;
            wq(Q); scl_pull = 1'b1; wq(Q);
          end
          chk(oe_seen == 0, "R2 foreign transfer stays released", 64'(oe_seen), 64'd0);
        end
        bus_stop();
      end
    end
    chk(cfg_bytes == DEF, "R2 foreign transfers change nothing", 64'(cfg_bytes), 64'(DEF));

    // R3/R4: every write length, each followed by a full read
    for (int n = 0; n <= NREG; n++) begin
      do_write(n, n + 1);
      wq(4);
      chk(cfg_bytes == model_flat(), $sformatf("R4 after write of %0d bytes", n),
          64'(cfg_bytes), 64'(model_flat()));
      do_read(NREG);
    end

    // R5: overlong write saturates, no wrap into register 0
    do_write(NREG + 3, 9);
    wq(4);
    chk(cfg_bytes == model_flat(), "R5 overlong write", 64'(cfg_bytes), 64'(model_flat()));

    // R7: NACK after each possible byte, then a normal transfer
    for (int k = 0; k <= NREG; k++) do_read(k);
    do_read(NREG);

    // R8: start inside a data byte restarts address reception
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h06, ack);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(8'hD2, ack);
    chk(ack, "R8 address after mid-byte start", 64'(ack), 64'd1);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    send_byte(8'h9D, ack);
    model[0] = 8'h9D;
    // repeated start straight into a read
    bus_start();
    send_byte(8'hD3, ack);
    chk(ack, "R8 read after repeated start", 64'(ack), 64'd1);
    begin
      logic [7:0] b;
      recv_byte(1'b1, b);
      chk(b == 8'd6, "R8 length after repeated start", 64'(b), 64'd6);
      recv_byte(1'b0, b);
      chk(b == 8'h9D, "R8 reg0 after repeated start", 64'(b), 64'h9D);
    end
    bus_stop();
    wq(4);
    chk(cfg_bytes == model_flat(), "R8 registers after restarts", 64'(cfg_bytes), 64'(model_flat()));

    // R8: stop inside the address byte, then a normal write
    bus_start();
    send_bits(8'hD2, 5);
    bus_stop();
    do_write(2, 4);
    wq(4);
    chk(cfg_bytes == model_flat(), "R8 write after aborted address", 64'(cfg_bytes), 64'(model_flat()));

    finish_run();
  end

endmodule